// File: doc/BRIEF.md
# Peripheral DMA Channel Engine

A single-channel DMA engine that copies 32-bit words between a peripheral-side port and a memory-side port. Software sets it up through a seven-word register file. The registers hold a global run gate, a control word, a status word, and a pointer and a sequencing word for each side. The engine then moves a programmed number of words. Each word is first read from the source port and then written unchanged to the sink port. Both ports use a plain valid/ready word handshake, with a write-enable that marks the write phase.

The engine runs in one of three modes. One-shot mode stops after a single count. Continuous single-buffer mode restarts by itself from the programmed pointers and count. Continuous double-buffer mode treats the count as half of a ping-pong buffer and reports at both halves. Pointer and count writes made while a transfer runs are held as shadow values and take effect only at a buffer boundary. Each side can wrap its pointer inside an aligned power-of-two window. Bursts can be paced by a selected peripheral request line. An end-of-count event sets a pending bit that software clears by writing a one to it, and it drives `irq` when both interrupt enables are set.

Top module: `pdma_channel`

## Requirements
- R1: Register word offsets on `reg_addr` are: 0 general, 1 control, 2 status, 3 memory pointer, 4 memory sequencing, 5 peripheral pointer, 6 peripheral sequencing. After reset every register reads zero, neither port asserts valid, and `irq` is low.
- R2: Control bit 31 is the enable and bits 15:2 hold the count C. Writing the control word with bit 31 set while the engine is idle starts a transfer of C+1 words, and status bit 31 (busy) reads 1 until the transfer stops. Each word is read from the source port and written unchanged to the sink port. Control bit 28 sets the direction: 0 moves peripheral to memory, 1 moves memory to peripheral. Pointers are byte addresses and advance by 4 per word.
- R3: With control bit 27 (one-shot) set, completion of the count clears busy, makes control bit 31 read 0 and sets status bit 30 (pending). `irq` is high while pending, control bit 30 and memory-sequencing bit 31 are all set.
- R4: Writing status with bit 30 set clears the pending bit and drops `irq`.
- R5: With one-shot clear and memory-sequencing bit 19 clear, the engine restarts at each count end from the programmed pointers and count. A pointer written while busy is first used at the next buffer boundary.
- R6: With memory-sequencing bit 19 set, the count is half a buffer. Pending is set and status bit 28 (phase) becomes 1 at the half-way point, while the pointers keep advancing. At the end of the full buffer the phase returns to 0, pending is set again, and the pointers reload from the programmed values.
- R7: Peripheral-sequencing bits 18:16 give a wrap index k. For k=0 there is no wrap; otherwise the address wraps inside an aligned window of 2^(k-1) words.
- R8: Memory-sequencing bits 18:16 give a wrap index k. For k=0 there is no wrap; otherwise the address wraps inside an aligned window of 2^(k+4) words.
- R9: With control bit 21 (flow) set, a burst starts only in a cycle where `dreq` bit sel is high, where sel is control bits 20:16. The burst length comes from memory-sequencing bits 26:24: code 5 gives 4 words, code 6 gives 8 words, and any other code gives 1 word.
- R10: General-register bit 31 clear freezes the engine: no valid is asserted and the count holds, and status bit 29 (halted) reads 1 while busy. Setting the bit again resumes the transfer and it completes correctly.
- R11: Writing control with bit 31 clear while busy stops the engine within one cycle. Status bits 15:2 then still show the remaining count minus one, which is C minus the number of words written.
- R12: Control bit 29 (hold) pauses a running transfer in the same way as R10 and sets status bit 29. Clearing it resumes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 2**SEL_W | Peripheral request lines |
| per_valid | output | 1 | Peripheral port access valid |
| per_we | output | 1 | Peripheral port write (1) or read (0) |
| per_addr | output | 32 | Peripheral byte address |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, taken with ready |
| per_ready | input | 1 | Peripheral accepts the access |
| mem_valid | output | 1 | Memory port access valid |
| mem_we | output | 1 | Memory port write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken with ready |
| mem_ready | input | 1 | Memory accepts the access |
| irq | output | 1 | End-of-count interrupt |

## Verification
The bench uses the default parameters: a 14-bit count field and a 5-bit request select over 32 request lines. Pacing is tested by pulsing line 5 against a neighbouring line 4, so a select decode that is off by one shows up. The wide count allows runs of 100 words, which leaves room to freeze, hold and abort a transfer in the middle. Random wrap indices on both sides cover the smallest peripheral window of one word and memory windows that a short run crosses.

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int CNT_W = 14,
  parameter int SEL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [(1<<SEL_W)-1:0]   dreq,
  output logic                    per_valid,
  output logic                    per_we,
  output logic [31:0]             per_addr,
  output logic [31:0]             per_wdata,
  input  logic [31:0]             per_rdata,
  input  logic                    per_ready,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  input  logic                    mem_ready,
  output logic                    irq
);
  localparam int WA = 30;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_RD, S_WR} st_t;
  st_t state;

  logic             gen_en;
  logic             c_en, c_ie, c_hold, c_dir, c_once, c_flow;
  logic [SEL_W-1:0] c_sel;
  logic [CNT_W-1:0] c_cnt;
  logic             m_ie, m_dbl;
  logic [2:0]       m_burst, m_wrap, p_wrap;
  logic [WA-1:0]    mptr_q, pptr_q, m_cur, p_cur;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bcnt;
  logic             pend, phase;
  logic [31:0]      dbuf;

  logic busy, go, halted, last, rd_fire, wr_fire, eoc, src_rdy, snk_rdy;
  logic [WA-1:0] p_mask, m_mask, p_nxt, m_nxt;
  logic [2:0] blen;
  logic [13:0] cnt14, ccnt14;
  logic unused_bits;

  function automatic logic [WA-1:0] step(input logic [WA-1:0] a, input logic [WA-1:0] msk);
    step = (a & ~msk) | ((a + 1'b1) & msk);
  endfunction

  assign busy    = (state != S_IDLE);
  assign go      = gen_en & ~c_hold;
  assign halted  = busy & ~go;
  assign last    = (cnt == '0);
  assign src_rdy = c_dir ? mem_ready : per_ready;
  assign snk_rdy = c_dir ? per_ready : mem_ready;
  assign rd_fire = go && state == S_RD && src_rdy;
  assign wr_fire = go && state == S_WR && snk_rdy;
  assign eoc     = wr_fire & last;

  assign p_mask = (p_wrap == 3'd0) ? '1 : ((WA'(1) << (p_wrap - 3'd1)) - WA'(1));
  assign m_mask = (m_wrap == 3'd0) ? '1 : ((WA'(1) << ({1'b0, m_wrap} + 4'd4)) - WA'(1));
  assign p_nxt  = step(p_cur, p_mask);
  assign m_nxt  = step(m_cur, m_mask);

  always_comb begin
    case (m_burst)
      3'd5:    blen = 3'd3;
      3'd6:    blen = 3'd7;
      default: blen = 3'd0;
    endcase
  end

  assign per_valid = go && ((state == S_RD && !c_dir) || (state == S_WR && c_dir));
  assign mem_valid = go && ((state == S_RD && c_dir) || (state == S_WR && !c_dir));
  assign per_we    = (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign per_addr  = {p_cur, 2'b00};
  assign mem_addr  = {m_cur, 2'b00};
  assign per_wdata = dbuf;
  assign mem_wdata = dbuf;
  assign irq       = pend & c_ie & m_ie;

  assign cnt14  = 14'(cnt);
  assign ccnt14 = 14'(c_cnt);
  assign unused_bits = ^reg_wdata;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {gen_en, 31'b0};
      3'd1:    reg_rdata = {c_en, c_ie, c_hold, c_dir, c_once, 5'b0, c_flow, 5'(c_sel), ccnt14, 2'b00};
      3'd2:    reg_rdata = {busy, pend, halted, phase, 12'b0, cnt14, 2'b00};
      3'd3:    reg_rdata = {mptr_q, 2'b00};
      3'd4:    reg_rdata = {m_ie, 4'b0, m_burst, 4'b0, m_dbl, m_wrap, 16'b0};
      3'd5:    reg_rdata = {pptr_q, 2'b00};
      3'd6:    reg_rdata = {13'b0, p_wrap, 16'b0};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      gen_en  <= 1'b0;
      c_en    <= 1'b0; c_ie <= 1'b0; c_hold <= 1'b0; c_dir <= 1'b0;
      c_once  <= 1'b0; c_flow <= 1'b0; c_sel <= '0; c_cnt <= '0;
      m_ie    <= 1'b0; m_dbl <= 1'b0; m_burst <= '0; m_wrap <= '0; p_wrap <= '0;
      mptr_q  <= '0; pptr_q <= '0; m_cur <= '0; p_cur <= '0;
      cnt     <= '0; bcnt <= '0; pend <= 1'b0; phase <= 1'b0; dbuf <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd2 && reg_wdata[30]) pend <= 1'b0;

      case (state)
        S_ARB: if (go && (!c_flow || dreq[c_sel])) begin
          state <= S_RD;
          bcnt  <= blen;
        end
        S_RD: if (rd_fire) begin
          dbuf  <= c_dir ? mem_rdata : per_rdata;
          state <= S_WR;
        end
        S_WR: if (wr_fire) begin
          if (last) begin
            pend <= 1'b1;
            if (c_once) begin
              state <= S_IDLE;
              c_en  <= 1'b0;
              p_cur <= p_nxt;
              m_cur <= m_nxt;
            end else if (m_dbl && !phase) begin
              phase <= 1'b1;
              cnt   <= c_cnt;
              p_cur <= p_nxt;
              m_cur <= m_nxt;
              state <= S_ARB;
            end else begin
              phase <= 1'b0;
              cnt   <= c_cnt;
              p_cur <= pptr_q;
              m_cur <= mptr_q;
              state <= S_ARB;
            end
          end else begin
            cnt   <= cnt - 1'b1;
            p_cur <= p_nxt;
            m_cur <= m_nxt;
            bcnt  <= bcnt - 1'b1;
            state <= (bcnt == 3'd0) ? S_ARB : S_RD;
          end
        end
        default: ;
      endcase

      if (reg_wr) begin
        case (reg_addr)
          3'd0: gen_en <= reg_wdata[31];
          3'd1: begin
            c_en   <= reg_wdata[31];
            c_ie   <= reg_wdata[30];
            c_hold <= reg_wdata[29];
            c_dir  <= reg_wdata[28];
            c_once <= reg_wdata[27];
            c_flow <= reg_wdata[21];
            c_sel  <= reg_wdata[16 +: SEL_W];
            c_cnt  <= reg_wdata[2 +: CNT_W];
            if (!busy && reg_wdata[31]) begin
              state <= S_ARB;
              cnt   <= reg_wdata[2 +: CNT_W];
              m_cur <= mptr_q;
              p_cur <= pptr_q;
              phase <= 1'b0;
            end else if (busy && !reg_wdata[31]) begin
              state <= S_IDLE;
            end
          end
          3'd3: mptr_q <= reg_wdata[31:2];
          3'd4: begin
            m_ie    <= reg_wdata[31];
            m_burst <= reg_wdata[26:24];
            m_dbl   <= reg_wdata[19];
            m_wrap  <= reg_wdata[18:16];
          end
          3'd5: pptr_q <= reg_wdata[31:2];
          3'd6: p_wrap <= reg_wdata[18:16];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdma_channel_sva.sv
module pdma_channel_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        go,
  input logic        pend,
  input logic        phase,
  input logic        eoc,
  input logic        c_once,
  input logic        m_dbl,
  input logic        per_valid,
  input logic        mem_valid,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata
);
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_valid && mem_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!per_valid && !mem_valid)); // R1
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!per_valid && !mem_valid)); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && !reg_wdata[31]) |=> !busy); // R11
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && reg_wdata[30] && !eoc) |=> !pend); // R4
  AST_EOC_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> pend); // R3
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && c_once && !(reg_wr && reg_addr == 3'd1)) |=> !busy); // R3
  AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && m_dbl && !c_once && !(reg_wr && reg_addr == 3'd1)) |=> (phase != $past(phase))); // R6
endmodule

bind pdma_channel pdma_channel_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .go(go), .pend(pend), .phase(phase),
  .eoc(eoc), .c_once(c_once), .m_dbl(m_dbl), .per_valid(per_valid),
  .mem_valid(mem_valid), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/pdma_channel_test.sv
module pdma_channel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] dreq = '0;
  logic        per_valid, per_we, mem_valid, mem_we, irq;
  logic [31:0] per_addr, per_wdata, per_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        per_ready = 1'b0, mem_ready = 1'b0;

  pdma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq(dreq),
    .per_valid(per_valid), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ready(per_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq));

  assign per_rdata = per_addr ^ 32'h5A00_0000;
  assign mem_rdata = ~mem_addr;

  localparam logic [31:0] EN = 32'h8000_0000, IE = 32'h4000_0000, HOLD = 32'h2000_0000,
                          DIR = 32'h1000_0000, ONCE = 32'h0800_0000, FLOW = 32'h0020_0000;

  int nchk = 0, nfail = 0, nwr = 0, cyc = 0;
  bit rdy_en = 1'b1;
  logic [31:0] lg_addr [0:255];
  logic [31:0] lg_data [0:255];
  logic        lg_side [0:255];

  always @(negedge clk) begin
    #1;
    per_ready = rdy_en && ($urandom_range(3) != 0);
    mem_ready = rdy_en && ($urandom_range(3) != 0);
    if (per_valid && per_we && per_ready && nwr < 256) begin
      lg_addr[nwr] = per_addr; lg_data[nwr] = per_wdata; lg_side[nwr] = 1'b0; nwr++;
    end
    if (mem_valid && mem_we && mem_ready && nwr < 256) begin
      lg_addr[nwr] = mem_addr; lg_data[nwr] = mem_wdata; lg_side[nwr] = 1'b1; nwr++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd2, s);
      if (!s[31]) break;
    end
  endtask

  task automatic wait_nwr(input int n);
    for (int i = 0; i < 5000; i++) begin
      if (nwr >= n) break;
      @(negedge clk);
    end
  endtask

  function automatic int pwin(input int k); return (k == 0) ? 0 : (1 << (k - 1)); endfunction
  function automatic int mwin(input int k); return (k == 0) ? 0 : (1 << (k + 4)); endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int w, input int j);
    logic [31:0] win;
    int off;
    if (w == 0) return base + 32'(4 * j);
    win = base & ~(32'(w * 4) - 32'd1);
    off = int'((base - win) >> 2);
    return win + 32'(((off + j) % w) * 4);
  endfunction

  task automatic check_log(input string tag, input int first, input int n, input bit dir,
                           input logic [31:0] pb, input int pw, input logic [31:0] mb, input int mw);
    logic [31:0] pa, ma;
    for (int j = 0; j < n; j++) begin
      pa = exp_addr(pb, pw, j);
      ma = exp_addr(mb, mw, j);
      chk({tag, " side"}, 32'(lg_side[first + j]), dir ? 32'd0 : 32'd1);
      chk({tag, " addr"}, lg_addr[first + j], dir ? pa : ma);
      chk({tag, " data"}, lg_data[first + j], dir ? ~ma : (pa ^ 32'h5A00_0000));
    end
  endtask

  task automatic prog(input logic [31:0] pb, input int pk, input logic [31:0] mb, input int mk,
                      input logic [31:0] mextra);
    wr(3'd5, pb); wr(3'd6, 32'(pk) << 16);
    wr(3'd3, mb); wr(3'd4, mextra | (32'(mk) << 16));
  endtask

  task automatic fresh();
    wr(3'd2, IE);
    nwr = 0; rdy_en = 1'b1; dreq = '0;
  endtask

  initial begin
    logic [31:0] v, s0, s1;
    int n0;
    void'($urandom(32'h0000_2A17));

    // R1 reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 32'd0);
    end
    chk("R1 reset quiet", {29'd0, per_valid, mem_valid, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd2, v); chk("R1 status after release", v, 32'd0);

    wr(3'd0, EN);

    // R2 R3 R7 one-shot peripheral to memory, 1-word peripheral window
    fresh();
    prog(32'h0000_0100, 1, 32'h0000_2000, 0, 32'h8000_0000);
    wr(3'd1, EN | IE | ONCE | (32'd5 << 2));
    wait_idle();
    chk("R2 word count", 32'(nwr), 32'd6);
    check_log("R2 R7 p2m", 0, 6, 1'b0, 32'h100, pwin(1), 32'h2000, 0);
    rd(3'd1, v); chk("R3 enable self-clears", v, IE | ONCE | (32'd5 << 2));
    rd(3'd2, v); chk("R3 status pending", v, 32'h4000_0000);
    chk("R3 irq raised", 32'(irq), 32'd1);
    wr(3'd2, 32'h4000_0000);
    rd(3'd2, v); chk("R4 pending cleared", v, 32'd0);
    chk("R4 irq dropped", 32'(irq), 32'd0);

    // R2 R7 memory to peripheral, 4-word peripheral window
    fresh();
    prog(32'h0000_0048, 3, 32'h0000_4000, 0, 32'h0);
    wr(3'd1, EN | ONCE | DIR | (32'd6 << 2));
    wait_idle();
    chk("R2 m2p count", 32'(nwr), 32'd7);
    check_log("R2 R7 m2p wrap", 0, 7, 1'b1, 32'h48, pwin(3), 32'h4000, 0);
    chk("R3 irq masked without enables", 32'(irq), 32'd0);

    // R8 memory window of 32 words
    fresh();
    prog(32'h0000_0200, 0, 32'h0000_3078, 1, 32'h0);
    wr(3'd1, EN | ONCE | (32'd3 << 2));
    wait_idle();
    check_log("R8 mem wrap", 0, 4, 1'b0, 32'h200, 0, 32'h3078, mwin(1));

    // R9 flow control on request line 5, burst code 5
    fresh();
    prog(32'h0000_0300, 1, 32'h0000_5000, 0, 32'h0500_0000);
    wr(3'd1, EN | ONCE | FLOW | (32'd5 << 16) | (32'd7 << 2));
    repeat (30) @(negedge clk);
    chk("R9 no request no traffic", 32'(nwr), 32'd0);
    dreq[4] = 1'b1;
    repeat (20) @(negedge clk);
    dreq = '0;
    chk("R9 other line ignored", 32'(nwr), 32'd0);
    dreq[5] = 1'b1; @(negedge clk); dreq = '0;
    repeat (60) @(negedge clk);
    chk("R9 one burst of 4", 32'(nwr), 32'd4);
    dreq[5] = 1'b1; @(negedge clk); dreq = '0;
    wait_idle();
    chk("R9 second burst", 32'(nwr), 32'd8);
    check_log("R9 burst data", 0, 8, 1'b0, 32'h300, pwin(1), 32'h5000, 0);

    // R10 global freeze and resume
    fresh();
    prog(32'h0000_0400, 0, 32'h0000_6000, 0, 32'h0);
    wr(3'd1, EN | ONCE | (32'd19 << 2));
    wait_nwr(5);
    wr(3'd0, 32'd0);
    repeat (2) @(negedge clk);
    n0 = nwr;
    rd(3'd2, s0);
    repeat (20) @(negedge clk);
    rd(3'd2, s1);
    chk("R10 frozen no writes", 32'(nwr), 32'(n0));
    chk("R10 frozen count held", s1, s0);
    chk("R10 halted busy", s1 & 32'hE000_0000, 32'hA000_0000);
    wr(3'd0, EN);
    wait_idle();
    chk("R10 resumed count", 32'(nwr), 32'd20);
    check_log("R10 resumed data", 0, 20, 1'b0, 32'h400, 0, 32'h6000, 0);

    // R12 hold
    fresh();
    prog(32'h0000_0500, 1, 32'h0000_7000, 0, 32'h0);
    wr(3'd1, EN | ONCE | HOLD | (32'd7 << 2));
    repeat (20) @(negedge clk);
    rd(3'd2, v);
    chk("R12 held status", v, 32'hA000_001C);
    chk("R12 held no writes", 32'(nwr), 32'd0);
    wr(3'd1, EN | ONCE | (32'd7 << 2));
    wait_idle();
    check_log("R12 released", 0, 8, 1'b0, 32'h500, pwin(1), 32'h7000, 0);

    // R11 abort keeps remaining count
    fresh();
    prog(32'h0000_0600, 1, 32'h0000_8000, 0, 32'h0);
    wr(3'd1, EN | ONCE | (32'd99 << 2));
    wait_nwr(10);
    rdy_en = 1'b0;
    repeat (3) @(negedge clk);
    n0 = nwr;
    wr(3'd1, ONCE | (32'd99 << 2));
    rd(3'd2, v);
    chk("R11 busy cleared", v & 32'h8000_0000, 32'd0);
    chk("R11 remaining count", (v >> 2) & 32'h3FFF, 32'(99 - n0));
    rdy_en = 1'b1;
    repeat (15) @(negedge clk);
    chk("R11 no traffic after abort", {30'd0, per_valid, mem_valid} | 32'(nwr - n0), 32'd0);

    // R5 continuous single buffer with shadowed pointer
    fresh();
    prog(32'h0000_0700, 1, 32'h0000_9000, 0, 32'h0);
    wr(3'd1, EN | (32'd3 << 2));
    wr(3'd3, 32'h0000_A000);
    wait_nwr(8);
    rdy_en = 1'b0;
    repeat (3) @(negedge clk);
    wr(3'd1, 32'd0);
    check_log("R5 first buffer", 0, 4, 1'b0, 32'h700, pwin(1), 32'h9000, 0);
    check_log("R5 reloaded buffer", 4, 4, 1'b0, 32'h700, pwin(1), 32'hA000, 0);

    // R6 double buffer
    fresh();
    prog(32'h0000_0800, 1, 32'h0000_B000, 0, 32'h0008_0000);
    wr(3'd1, EN | (32'd1 << 2));
    wr(3'd3, 32'h0000_C000);
    wait_nwr(2);
    rd(3'd2, v);
    chk("R6 half pending and phase", v & 32'h5000_0000, 32'h5000_0000);
    wr(3'd2, 32'h4000_0000);
    wait_nwr(4);
    rd(3'd2, v);
    chk("R6 full pending phase back", v & 32'h5000_0000, 32'h4000_0000);
    wait_nwr(8);
    rdy_en = 1'b0;
    repeat (3) @(negedge clk);
    wr(3'd1, 32'd0);
    check_log("R6 first buffer", 0, 4, 1'b0, 32'h800, pwin(1), 32'hB000, 0);
    check_log("R6 second buffer", 4, 4, 1'b0, 32'h800, pwin(1), 32'hC000, 0);

    // R2 R7 R8 random one-shot runs
    for (int t = 0; t < 8; t++) begin
      bit dir;
      int c, pk, mk;
      logic [31:0] pb, mb, bc;
      dir = 1'($urandom_range(1));
      c   = $urandom_range(15);
      pk  = $urandom_range(7);
      mk  = $urandom_range(7);
      pb  = {16'd0, 16'($urandom)} & 32'hFFFC;
      mb  = {12'd1, 20'($urandom)} & 32'hFFFF_FFFC;
      bc  = 32'($urandom_range(3) + 3) << 24;
      fresh();
      prog(pb, pk, mb, mk, bc);
      wr(3'd1, EN | ONCE | (dir ? DIR : 32'd0) | (32'(c) << 2));
      wait_idle();
      chk("R2 random count", 32'(nwr), 32'(c + 1));
      check_log("R2 R7 R8 random", 0, c + 1, dir, pb, pwin(pk), mb, mwin(mk));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule